// File: doc/BRIEF.md
# Dual-Set Split-Bus Access Protection Checker

This block sits next to a processor core that has separate instruction-fetch and data buses. Each cycle it takes one fetch address and one data access (a read or a write) and tests both against the protection set that is currently active. When an access is not permitted, it raises a trap request with a cause code one cycle later, and at the same moment it sends a matching pulse to a trace port. It also keeps the address that faulted.

There are two independent protection sets. The `set_sel` input, which stands for a processor status bit, chooses which one applies. Each set has a data half and a code half. The data half has four address windows, each with its own read-enable and write-enable bit. The code half has two windows, each with an execute-enable bit. Software loads the window bounds, the permission word and a global enable through a write-only configuration port.

Top module: `hvp_guard`

## Requirements
- R1: While `rst` is high, all state is cleared: the outputs `trap_req`, `dbg_pulse`, `trap_cause` and `fault_addr` read zero, the global enable is 0, and every bound and permission is 0.
- R2: Only the set chosen by `set_sel` (0 or 1) is used to judge the accesses of that cycle. The other set has no effect.
- R3: A data read is legal only if some data window of the active set contains the address and that window's read bit is set.
- R4: A data write is legal only if some data window of the active set contains the address and that window's write bit is set.
- R5: An instruction fetch is legal only if some code window of the active set contains the address and that window's execute bit is set.
- R6: A window contains address A when low <= A < high, compared as unsigned 32-bit values. A window whose low bound is greater than or equal to its high bound contains no address.
- R7: `trap_cause` is 2'b01 for an illegal data read, 2'b10 for an illegal data write, 2'b11 for an illegal fetch, and 2'b00 when there is no trap. If both buses fault in the same cycle, the fetch code is reported.
- R8: `trap_req` and `dbg_pulse` go high in the cycle after the strobed access that faulted. They stay high for exactly one cycle per faulting access cycle.
- R9: On a trap, `fault_addr` takes the fetch address if the fetch faulted, and the data address otherwise. When there is no trap, it holds its value.
- R10: While the global enable bit is 0, no access traps.
- R11: A configuration write in the same cycle as an access takes effect from the next cycle. The access in that cycle is judged with the old contents.
- R12: Configuration map, indexed by `cfg_addr`. Bits [5:4] = 00 selects control, and there word 0, bit 0 is the global enable. Bits [5:4] = 01 selects set 0 and 10 selects set 1. Within a set, word 2i/2i+1 is the low/high bound of data window i (i = 0..3), and word 8+2j/9+2j is the low/high bound of code window j (j = 0..1). Word 12 is the permission word: bit 2i is the read bit of data window i, bit 2i+1 its write bit, and bit 8+j the execute bit of code window j. All other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_sel | input | 1 | Chooses protection set 0 or 1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| ifetch_valid | input | 1 | Instruction fetch strobe |
| ifetch_addr | input | 32 | Instruction fetch address |
| dacc_valid | input | 1 | Data access strobe |
| dacc_write | input | 1 | 1 = data write, 0 = data read |
| dacc_addr | input | 32 | Data access address |
| trap_req | output | 1 | Registered trap request |
| trap_cause | output | 2 | Registered cause code |
| dbg_pulse | output | 1 | Registered trace pulse for a violation |
| fault_addr | output | 32 | Address of the most recent violation |

## Verification
A wrong bound, permission bit or enable held inside the block shows at the ports one cycle after the first access that depends on it. It appears as a missing or extra trap, or as the wrong cause. A wrong set selection appears the same way, as soon as the two sets differ for an access. A stale or wrongly chosen latched address shows on `fault_addr` right after the trap edge and stays visible until the next violation. This is why every cycle compares all four outputs against a reference built from the configuration map.

// File: rtl/hvp_pkg.sv
package hvp_pkg;
  // Cause codes reported with a trap
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_READ  = 2'b01,
    CAUSE_WRITE = 2'b10,
    CAUSE_FETCH = 2'b11
  } cause_e;

  // Control page of the configuration space
  localparam int unsigned PAGE_CTRL = 0;
  localparam int unsigned WORD_ENABLE = 0;
endpackage

// File: rtl/hvp_range_match.sv
module hvp_range_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic nonempty;
  logic above_lo;
  logic below_hi;

  always_comb begin
    nonempty = lo < hi;
    above_lo = addr >= lo;
    below_hi = addr < hi;
    hit      = nonempty && above_lo && below_hi;
  end
endmodule

// File: rtl/hvp_side.sv
module hvp_side #(
  parameter int ADDR_W = 32,
  parameter int N_WIN  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo [N_WIN],
  input  logic [ADDR_W-1:0] hi [N_WIN],
  input  logic [N_WIN-1:0]  perm,
  output logic              ok
);
  logic [N_WIN-1:0] hit;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    hvp_range_match #(.ADDR_W(ADDR_W)) u_match (
      .lo   (lo[g]),
      .hi   (hi[g]),
      .addr (addr),
      .hit  (hit[g])
    );
  end

  assign ok = |(hit & perm);
endmodule

// File: rtl/hvp_regfile.sv
module hvp_regfile
  import hvp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_DATA = 4,
  parameter int N_CODE = 2,
  parameter int CFG_AW = 6,
  localparam int N_TOT  = N_DATA + N_CODE,
  localparam int MODE_W = 2 * N_DATA + N_CODE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              set_sel,
  output logic [ADDR_W-1:0] act_lo [N_TOT],
  output logic [ADDR_W-1:0] act_hi [N_TOT],
  output logic [MODE_W-1:0] act_mode,
  output logic              glb_en
);
  localparam int N_SETS   = 2;
  localparam int WORD_W   = CFG_AW - 2;
  localparam int MODE_IDX = 2 * N_TOT;

  logic [ADDR_W-1:0] lo_q   [N_SETS][N_TOT];
  logic [ADDR_W-1:0] hi_q   [N_SETS][N_TOT];
  logic [MODE_W-1:0] mode_q [N_SETS];
  logic              en_q;

  int page_n;
  int word_n;

  always_comb begin
    page_n = int'(cfg_addr[CFG_AW-1:WORD_W]);
    word_n = int'(cfg_addr[WORD_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      for (int s = 0; s < N_SETS; s++) begin
        mode_q[s] <= '0;
        for (int k = 0; k < N_TOT; k++) begin
          lo_q[s][k] <= '0;
          hi_q[s][k] <= '0;
        end
      end
    end else if (cfg_we) begin
      if (page_n == int'(PAGE_CTRL) && word_n == int'(WORD_ENABLE))
        en_q <= cfg_wdata[0];
      for (int s = 0; s < N_SETS; s++) begin
        if (page_n == s + 1) begin
          for (int k = 0; k < N_TOT; k++) begin
            if (word_n == 2 * k)     lo_q[s][k] <= cfg_wdata[ADDR_W-1:0];
            if (word_n == 2 * k + 1) hi_q[s][k] <= cfg_wdata[ADDR_W-1:0];
          end
          if (word_n == MODE_IDX) mode_q[s] <= cfg_wdata[MODE_W-1:0];
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < N_TOT; k++) begin
      act_lo[k] = lo_q[set_sel][k];
      act_hi[k] = hi_q[set_sel][k];
    end
    act_mode = mode_q[set_sel];
    glb_en   = en_q;
  end
endmodule

// File: rtl/hvp_trap_unit.sv
module hvp_trap_unit
  import hvp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_en,
  input  logic              if_valid,
  input  logic [ADDR_W-1:0] if_addr,
  input  logic              code_ok,
  input  logic              d_valid,
  input  logic              d_write,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic              data_ok,
  output logic              trap_q,
  output logic [1:0]        cause_q,
  output logic              dbg_q,
  output logic [ADDR_W-1:0] fault_q
);
  logic code_bad;
  logic data_bad;

  always_comb begin
    code_bad = glb_en && if_valid && !code_ok;
    data_bad = glb_en && d_valid && !data_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_q  <= 1'b0;
      dbg_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
      fault_q <= '0;
    end else begin
      trap_q <= code_bad || data_bad;
      dbg_q  <= code_bad || data_bad;
      if (code_bad) begin
        cause_q <= CAUSE_FETCH;
        fault_q <= if_addr;
      end else if (data_bad) begin
        cause_q <= d_write ? CAUSE_WRITE : CAUSE_READ;
        fault_q <= d_addr;
      end else begin
        cause_q <= CAUSE_NONE;
      end
    end
  end

  AST_TRACE_TRACKS_TRAP: assert property (@(posedge clk) disable iff (rst) trap_q == dbg_q); // R8
  AST_CAUSE_WITH_TRAP: assert property (@(posedge clk) disable iff (rst) trap_q == (cause_q != CAUSE_NONE)); // R7
  AST_FETCH_WINS: assert property (@(posedge clk) disable iff (rst) $past(glb_en && if_valid && !code_ok) |-> cause_q == CAUSE_FETCH); // R7
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst) !$past(glb_en) |-> !trap_q); // R10
  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (rst) !trap_q |-> $stable(fault_q)); // R9
endmodule

// File: rtl/hvp_guard.sv
module hvp_guard
  import hvp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_DATA = 4,
  parameter int N_CODE = 2,
  parameter int CFG_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_sel,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              ifetch_valid,
  input  logic [ADDR_W-1:0] ifetch_addr,
  input  logic              dacc_valid,
  input  logic              dacc_write,
  input  logic [ADDR_W-1:0] dacc_addr,
  output logic              trap_req,
  output logic [1:0]        trap_cause,
  output logic              dbg_pulse,
  output logic [ADDR_W-1:0] fault_addr
);
  localparam int N_TOT  = N_DATA + N_CODE;
  localparam int MODE_W = 2 * N_DATA + N_CODE;

  logic [ADDR_W-1:0] act_lo [N_TOT];
  logic [ADDR_W-1:0] act_hi [N_TOT];
  logic [MODE_W-1:0] act_mode;
  logic              glb_en;

  logic [ADDR_W-1:0] d_lo [N_DATA];
  logic [ADDR_W-1:0] d_hi [N_DATA];
  logic [ADDR_W-1:0] c_lo [N_CODE];
  logic [ADDR_W-1:0] c_hi [N_CODE];
  logic [N_DATA-1:0] d_perm;
  logic [N_CODE-1:0] c_perm;
  logic              data_ok;
  logic              code_ok;

  hvp_regfile #(
    .ADDR_W(ADDR_W), .N_DATA(N_DATA), .N_CODE(N_CODE), .CFG_AW(CFG_AW)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .set_sel  (set_sel),
    .act_lo   (act_lo),
    .act_hi   (act_hi),
    .act_mode (act_mode),
    .glb_en   (glb_en)
  );

  for (genvar i = 0; i < N_DATA; i++) begin : g_data
    assign d_lo[i]   = act_lo[i];
    assign d_hi[i]   = act_hi[i];
    assign d_perm[i] = dacc_write ? act_mode[2*i+1] : act_mode[2*i];
  end

  for (genvar j = 0; j < N_CODE; j++) begin : g_code
    assign c_lo[j]   = act_lo[N_DATA+j];
    assign c_hi[j]   = act_hi[N_DATA+j];
    assign c_perm[j] = act_mode[2*N_DATA+j];
  end

  hvp_side #(.ADDR_W(ADDR_W), .N_WIN(N_DATA)) u_data_side (
    .addr (dacc_addr),
    .lo   (d_lo),
    .hi   (d_hi),
    .perm (d_perm),
    .ok   (data_ok)
  );

  hvp_side #(.ADDR_W(ADDR_W), .N_WIN(N_CODE)) u_code_side (
    .addr (ifetch_addr),
    .lo   (c_lo),
    .hi   (c_hi),
    .perm (c_perm),
    .ok   (code_ok)
  );

  hvp_trap_unit #(.ADDR_W(ADDR_W)) u_trap (
    .clk     (clk),
    .rst     (rst),
    .glb_en  (glb_en),
    .if_valid(ifetch_valid),
    .if_addr (ifetch_addr),
    .code_ok (code_ok),
    .d_valid (dacc_valid),
    .d_write (dacc_write),
    .d_addr  (dacc_addr),
    .data_ok (data_ok),
    .trap_q  (trap_req),
    .cause_q (trap_cause),
    .dbg_q   (dbg_pulse),
    .fault_q (fault_addr)
  );

  AST_NO_TRAP_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst) !$past(ifetch_valid || dacc_valid) |-> !trap_req); // R8
endmodule

// File: tb/hvp_guard_tb.sv
module hvp_guard_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_sel = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ifetch_valid = 1'b0;
  logic [31:0] ifetch_addr = '0;
  logic        dacc_valid = 1'b0;
  logic        dacc_write = 1'b0;
  logic [31:0] dacc_addr = '0;
  logic        trap_req;
  logic [1:0]  trap_cause;
  logic        dbg_pulse;
  logic [31:0] fault_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // reference state
  logic [31:0] lo_m [2][6];
  logic [31:0] hi_m [2][6];
  logic [9:0]  mode_m [2];
  bit          en_m;
  logic [31:0] fault_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  hvp_guard dut_i (
    .clk(clk), .rst(rst), .set_sel(set_sel), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ifetch_valid(ifetch_valid), .ifetch_addr(ifetch_addr),
    .dacc_valid(dacc_valid), .dacc_write(dacc_write), .dacc_addr(dacc_addr),
    .trap_req(trap_req), .trap_cause(trap_cause), .dbg_pulse(dbg_pulse),
    .fault_addr(fault_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit inside_win(logic [31:0] lo, logic [31:0] hi, logic [31:0] a);
    return (lo < hi) && (a >= lo) && (a < hi); // R6
  endfunction

  // kind: 0 read, 1 write, 2 fetch
  function automatic bit legal(int s, logic [31:0] a, int kind);
    bit r = 0;
    if (kind == 2) begin
      for (int j = 0; j < 2; j++)
        if (inside_win(lo_m[s][4+j], hi_m[s][4+j], a) && mode_m[s][8+j]) r = 1; // R5
    end else begin
      for (int i = 0; i < 4; i++)
        if (inside_win(lo_m[s][i], hi_m[s][i], a) && mode_m[s][2*i+kind]) r = 1; // R3 R4
    end
    return r;
  endfunction

  // R12 map
  function automatic void model_write(logic [5:0] wa, logic [31:0] wd);
    int page = int'(wa[5:4]);
    int word = int'(wa[3:0]);
    if (page == 0 && word == 0) en_m = wd[0];
    else if (page == 1 || page == 2) begin
      if (word < 12) begin
        if (word % 2 == 0) lo_m[page-1][word/2] = wd;
        else               hi_m[page-1][word/2] = wd;
      end else if (word == 12) mode_m[page-1] = wd[9:0];
    end
  endfunction

  task automatic step(input string tag, input bit sel, input bit iv, input logic [31:0] ia,
                      input bit dv, input bit dw, input logic [31:0] da,
                      input bit we, input logic [5:0] wa, input logic [31:0] wd);
    bit cb, db, et;
    logic [1:0] ec;
    set_sel = sel; ifetch_valid = iv; ifetch_addr = ia;
    dacc_valid = dv; dacc_write = dw; dacc_addr = da;
    cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    cb = en_m && iv && !legal(int'(sel), ia, 2);
    db = en_m && dv && !legal(int'(sel), da, dw ? 1 : 0);
    et = cb || db;
    ec = cb ? 2'b11 : db ? (dw ? 2'b10 : 2'b01) : 2'b00; // R7
    if (cb) fault_m = ia; else if (db) fault_m = da;      // R9
    @(posedge clk);
    if (we) model_write(wa, wd);                          // R11: after the access
    @(negedge clk);
    chk({tag, " trap"}, 32'(trap_req), 32'(et));
    chk({tag, " R8 dbg"}, 32'(dbg_pulse), 32'(et));
    chk({tag, " cause"}, 32'(trap_cause), 32'(ec));
    chk({tag, " fault"}, fault_addr, fault_m);
  endtask

  task automatic cfg(input logic [5:0] wa, input logic [31:0] wd);
    step("R12 cfg", 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, wa, wd);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd5151));
    for (int s = 0; s < 2; s++) begin
      mode_m[s] = '0;
      for (int k = 0; k < 6; k++) begin lo_m[s][k] = '0; hi_m[s][k] = '0; end
    end
    en_m = 0; fault_m = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 trap", 32'(trap_req), 0);
    chk("R1 dbg", 32'(dbg_pulse), 0);
    chk("R1 cause", 32'(trap_cause), 0);
    chk("R1 fault", fault_addr, 0);
    rst = 1'b0;

    // R10: disabled, an unprotected fetch does not trap
    step("R10 off", 0, 1, 32'h100, 1, 1, 32'h200, 0, 6'h0, 0);
    // R11: enable written while fetching: this access still uses old enable
    step("R11 same-cycle", 0, 1, 32'h100, 0, 0, 0, 1, 6'h00, 32'h1);
    step("R11 next-cycle", 0, 1, 32'h100, 0, 0, 0, 0, 6'h0, 0);

    // set 0: data win0 [0x40,0x80) read only; code win0 [0x00,0x40) exec
    cfg(6'h10, 32'h40); cfg(6'h11, 32'h80);
    cfg(6'h18, 32'h00); cfg(6'h19, 32'h40);
    cfg(6'h1C, 32'h101);
    // set 1: data win0 [0x40,0x80) read+write; no code
    cfg(6'h20, 32'h40); cfg(6'h21, 32'h80); cfg(6'h2C, 32'h003);

    step("R6 R3 low edge", 0, 0, 0, 1, 0, 32'h40, 0, 0, 0);
    step("R6 R3 top inside", 0, 0, 0, 1, 0, 32'h7F, 0, 0, 0);
    step("R6 R3 high edge", 0, 0, 0, 1, 0, 32'h80, 0, 0, 0);
    step("R4 write denied", 0, 0, 0, 1, 1, 32'h50, 0, 0, 0);
    step("R5 fetch ok", 0, 1, 32'h3C, 0, 0, 0, 0, 0, 0);
    step("R5 fetch bad", 0, 1, 32'h40, 0, 0, 0, 0, 0, 0);
    step("R7 both fault", 0, 1, 32'h44, 1, 1, 32'h90, 0, 0, 0);
    step("R9 hold", 0, 1, 32'h10, 1, 0, 32'h41, 0, 0, 0);
    step("R2 set1 write ok", 1, 0, 0, 1, 1, 32'h50, 0, 0, 0);
    step("R2 set1 fetch bad", 1, 1, 32'h10, 0, 0, 0, 0, 0, 0);
    // R6 empty window: lo == hi with all rights
    cfg(6'h12, 32'h90); cfg(6'h13, 32'h90); cfg(6'h1C, 32'h10F);
    step("R6 empty win", 0, 0, 0, 1, 0, 32'h90, 0, 0, 0);
    // R12 unmapped word ignored
    cfg(6'h1E, 32'hFFFF_FFFF);
    step("R12 ignored word", 0, 0, 0, 1, 1, 32'h88, 0, 0, 0);

    // constrained random with configuration traffic
    for (int n = 0; n < 3000; n++) begin
      bit we = ($urandom_range(0, 4) == 0);
      int page = $urandom_range(0, 2);
      logic [5:0] wa;
      logic [31:0] wd;
      wa = {page[1:0], (page == 0) ? 4'd0 : 4'($urandom_range(0, 13))};
      if (page == 0) wd = 32'($urandom_range(0, 9) != 0);
      else if (wa[3:0] == 4'd12) wd = $urandom();
      else wd = 32'($urandom_range(0, 255));
      step("R2 R3 R4 R5 R7 R9 R11 rnd", bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), 32'($urandom_range(0, 260)),
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           32'($urandom_range(0, 260)), we, wa, wd);
    end
    done = 1;
    finish_run();
  end
endmodule